// File: doc/BRIEF.md
# Parity Error Injection Controller

This block is a test aid for a multi-port egress bus. Each transfer on the bus opens with an address cycle that carries the logical port number. Data cycles for that port follow. The block drives the odd-parity bit for every bus cycle. On request, it inverts that bit exactly once, on a cycle aimed at the one logical port that software has chosen. The address and data bits are passed through untouched. Only the parity bit is corrupted.

Software writes a single control word. It holds a port number and two independent request flags, one for an address parity error and one for a data parity error. Each flag stays set until its single error has been applied, and the hardware then clears it. Software reads the same word back to poll for completion. A write to a flag that is still pending neither re-arms it nor cancels it.

Top module: `parity_inject_ctrl`

## Requirements
- R1: After reset, cfg_rdata reads 0: port field 0x00 and both request flags 0.
- R2: With no request pending, par_o equals the odd parity of bus_data, so that bus_data together with par_o holds an odd number of ones. This holds on both address and data cycles.
- R3: With the address request pending, par_o is inverted on the first cycle that meets all three conditions: bus_valid=1, bus_is_addr=1, and bus_data[7:0] equal to the selected port. Address cycles for other ports and data cycles are not affected.
- R4: With the data request pending, par_o is inverted only on the first valid data cycle (bus_is_addr=0) that follows a valid address cycle for the selected port. Later data cycles of that transfer are not affected, and neither are data cycles of transfers to other ports.
- R5: A request flag reads 0 from the clock edge that ends the cycle on which its error was applied. No further error is produced for that request.
- R6: A write to a request flag that is already pending has no effect. Writing 1 again does not produce a second error, and writing 0 does not cancel the request.
- R7: The control word layout is bits [7:0] for the port (0x00 to 0xFF), bit 8 for the address request and bit 9 for the data request. Every write replaces the port field, and that field is shared by both requests.
- R8: Cycles with bus_valid=0 never trigger or consume an injection.
- R9: If both requests are pending for the same port, the address cycle of a transfer to that port takes only the address error. The first data cycle that follows takes only the data error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | PORT_W+2 | Control word to write |
| cfg_rdata | output | PORT_W+2 | Current control word (port, request flags) |
| bus_valid | input | 1 | Bus cycle is valid |
| bus_is_addr | input | 1 | 1 marks an address cycle, 0 a data cycle |
| bus_data | input | DATA_W | Bus word; low PORT_W bits hold the port on address cycles |
| par_o | output | 1 | Odd parity of bus_data, inverted once when an injection fires |

## Verification
The checker tests the following on every cycle. Parity is correct whenever no request is pending. A pending address request always corrupts a matching valid address cycle and clears itself on the next edge. A pending flag survives any cycle that does not hit it, whatever is written. Some behaviour depends on the history of the transfer: the data error must land on the first data cycle after the selected port's address cycle and on no other data cycle. This only shows in the bench scenarios, which walk through mismatched ports, idle cycles, repeated writes, retargeting and simultaneous requests.

// File: rtl/parity_inject_ctrl.sv
module parity_inject_ctrl #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [PORT_W+1:0] cfg_wdata,
  output logic [PORT_W+1:0] cfg_rdata,
  input  logic              bus_valid,
  input  logic              bus_is_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              par_o
);

  localparam int AREQ_BIT = PORT_W;
  localparam int DREQ_BIT = PORT_W + 1;

  logic [PORT_W-1:0] sel_port;
  logic [PORT_W-1:0] cur_port;
  logic              areq, dreq, first_data;
  logic              addr_hit, data_hit;

  wire [PORT_W-1:0] bus_port = bus_data[PORT_W-1:0];

  assign addr_hit = areq & bus_valid & bus_is_addr & (bus_port == sel_port);
  assign data_hit = dreq & bus_valid & ~bus_is_addr & first_data & (cur_port == sel_port);

  assign par_o     = ~(^bus_data) ^ (addr_hit | data_hit);
  assign cfg_rdata = {dreq, areq, sel_port};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_port   <= '0;
      areq       <= 1'b0;
      dreq       <= 1'b0;
      cur_port   <= '0;
      first_data <= 1'b0;
    end else begin
      if (cfg_wr_en) sel_port <= cfg_wdata[PORT_W-1:0];
      if (areq) areq <= ~addr_hit;
      else if (cfg_wr_en) areq <= cfg_wdata[AREQ_BIT];
      if (dreq) dreq <= ~data_hit;
      else if (cfg_wr_en) dreq <= cfg_wdata[DREQ_BIT];
      if (bus_valid) begin
        if (bus_is_addr) begin
          cur_port   <= bus_port;
          first_data <= 1'b1;
        end else begin
          first_data <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/parity_inject_chk.sv
module parity_inject_chk #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [PORT_W+1:0] cfg_rdata,
  input logic              bus_valid,
  input logic              bus_is_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              par_o
);

  wire a_pend = cfg_rdata[PORT_W];
  wire d_pend = cfg_rdata[PORT_W+1];
  wire a_match = bus_valid && bus_is_addr && (bus_data[PORT_W-1:0] == cfg_rdata[PORT_W-1:0]);
  wire odd_ok = ((^bus_data) ^ par_o) == 1'b1;

  // R2
  clean_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pend && !d_pend) |-> odd_ok);

  // R3
  addr_corrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pend && a_match) |-> !odd_ok);

  // R5
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pend && a_match) |=> !a_pend);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pend && !a_match) |=> a_pend);

  // R8
  idle_no_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && (a_pend || d_pend)) |=> (a_pend == $past(a_pend)) && (d_pend == $past(d_pend)));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_pend && (!bus_valid || bus_is_addr)) |=> d_pend);

  // R1
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_rdata == '0) || !rst_n || $past(cfg_wr_en));

endmodule

bind parity_inject_ctrl parity_inject_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rdata(cfg_rdata),
  .bus_valid(bus_valid), .bus_is_addr(bus_is_addr), .bus_data(bus_data), .par_o(par_o)
);

// File: tb/sim_parity_inject_ctrl.sv
`timescale 1ns/1ps
module sim_parity_inject_ctrl;
  localparam int PW = 8;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0;
  logic [PW+1:0] cfg_wdata = '0;
  logic [PW+1:0] cfg_rdata;
  logic bus_valid = 0, bus_is_addr = 0;
  logic [DW-1:0] bus_data = '0;
  logic par_o;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  parity_inject_ctrl #(.PORT_W(PW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_valid(bus_valid), .bus_is_addr(bus_is_addr),
    .bus_data(bus_data), .par_o(par_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic dr, input logic ar, input logic [7:0] port);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wdata = {dr, ar, port};
    @(posedge clk);
    #1 cfg_wr_en = 0;
  endtask

  task automatic bus_cycle(input string req, input logic v, input logic a,
                           input logic [31:0] d, input logic flip);
    @(negedge clk);
    bus_valid = v; bus_is_addr = a; bus_data = d;
    #1 check(req, par_o, (~^d) ^ flip);
    @(posedge clk);
    #1 bus_valid = 0;
  endtask

  task automatic check_word(input string req, input logic [9:0] exp);
    @(negedge clk);
    check(req, cfg_rdata, exp);
  endtask

  task automatic t_reset;
    check_word("R1", 10'h000);
    bus_cycle("R1", 1, 0, 32'h0000_00FF, 0);
  endtask

  task automatic t_plain;
    bus_cycle("R2", 1, 1, 32'h0000_0000, 0);
    bus_cycle("R2", 1, 0, 32'hFFFF_FFFF, 0);
    bus_cycle("R2", 1, 0, 32'h1234_5677, 0);
    bus_cycle("R2", 0, 1, 32'h8000_0001, 0);
  endtask

  task automatic t_addr;
    cfg_write(0, 1, 8'h25);
    check_word("R7", 10'h125);
    bus_cycle("R3", 1, 1, 32'h0000_0024, 0);
    bus_cycle("R3", 1, 0, 32'h0000_0025, 0);
    check_word("R3", 10'h125);
    bus_cycle("R3", 1, 1, 32'hABCD_0025, 1);
    check_word("R5", 10'h025);
    bus_cycle("R5", 1, 1, 32'hABCD_0025, 0);
  endtask

  task automatic t_data;
    cfg_write(1, 0, 8'h80);
    bus_cycle("R4", 1, 1, 32'h0000_0010, 0);
    bus_cycle("R4", 1, 0, 32'h0000_0080, 0);
    bus_cycle("R4", 1, 1, 32'h0000_0080, 0);
    bus_cycle("R4", 0, 0, 32'h5555_0001, 0);
    bus_cycle("R4", 1, 0, 32'h5555_0001, 1);
    check_word("R5", 10'h080);
    bus_cycle("R4", 1, 0, 32'h5555_0001, 0);
    bus_cycle("R5", 1, 1, 32'h0000_0080, 0);
    bus_cycle("R5", 1, 0, 32'h0000_0003, 0);
  endtask

  task automatic t_invalid;
    cfg_write(0, 1, 8'h00);
    bus_cycle("R8", 0, 1, 32'h0000_0000, 0);
    check_word("R8", 10'h100);
    bus_cycle("R8", 1, 1, 32'h0000_0000, 1);
    check_word("R8", 10'h000);
  endtask

  task automatic t_pending;
    cfg_write(0, 1, 8'h3C);
    cfg_write(0, 1, 8'h3C);
    cfg_write(0, 0, 8'h3C);
    check_word("R6", 10'h13C);
    bus_cycle("R6", 1, 1, 32'h0000_003C, 1);
    bus_cycle("R6", 1, 1, 32'h0000_003C, 0);
    check_word("R6", 10'h03C);
  endtask

  task automatic t_retarget;
    cfg_write(0, 1, 8'h11);
    cfg_write(0, 0, 8'h22);
    check_word("R7", 10'h122);
    bus_cycle("R7", 1, 1, 32'h0000_0011, 0);
    bus_cycle("R7", 1, 1, 32'h0000_0022, 1);
  endtask

  task automatic t_both;
    cfg_write(1, 1, 8'hFF);
    check_word("R9", 10'h3FF);
    bus_cycle("R9", 1, 1, 32'h0000_00FF, 1);
    check_word("R9", 10'h2FF);
    bus_cycle("R9", 1, 0, 32'hDEAD_BEEF, 1);
    check_word("R9", 10'h0FF);
    bus_cycle("R9", 1, 0, 32'hDEAD_BEEF, 0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_plain();
    t_addr();
    t_data();
    t_invalid();
    t_pending();
    t_retarget();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule